// File: doc/BRIEF.md
# Single-Line Write-Back Buffer

This block parks one dirty cache line that the cache controller has just evicted, so the controller can fetch the replacement line straight away. It stores the line's physical line address (address bits above the 16-byte line offset) and the four 32-bit longwords of the line. It then writes them to external memory one longword at a time, during cycles when the external bus is not needed for a line fill.

The block shares the external bus with the cache fill engine through a small priority arbiter, and the fill engine always wins. A write-back burst starts only when no fill is requested. A fill request that arrives mid-burst takes the bus as soon as the longword in flight has been acknowledged. The burst then continues with the next longword once the fill has gone. CPU lookups into the cache are not involved, so they carry on while the buffer drains. A load offered while the buffer still holds a line is refused and reported.

Top module: `evict_line_buf`

## Requirements
- R1: After reset, `busy`, `ld_err`, `mem_wr_req` and `fill_gnt` are all low while `fill_req` is low.
- R2: When `ld_valid` and `ld_dirty` are both high on a clock edge while `busy` is low, the buffer captures `ld_tag` and `ld_line` and `busy` is high from the next cycle. Longword n of the line is `ld_line[32n+31:32n]`.
- R3: A load offered with `ld_dirty` low is ignored: `busy` stays low and no memory write is issued.
- R4: A longword write is never raised on a cycle that follows an edge where `fill_req` was high. `fill_gnt` is high exactly when `fill_req` is high and `mem_wr_req` is low, so the two are never both high.
- R5: Longwords are written in order 0, 1, 2, 3. Longword n goes to byte address `{tag, n[1:0], 2'b00}` and carries longword n of the captured line.
- R6: Once raised, `mem_wr_req` stays high with `mem_wr_addr` and `mem_wr_data` unchanged until an edge where `mem_wr_ack` is high. That edge completes the longword and drops the request.
- R7: If `fill_req` rises between longwords, no further longword is requested until `fill_req` falls. The burst then resumes at the next longword, with none repeated or skipped.
- R8: `busy` falls in the cycle after the acknowledge of longword 3, and a new load is accepted from then on.
- R9: A load offered while `busy` is high raises `ld_err` for exactly the next cycle and leaves the held line unchanged. This holds whether the offered line is dirty or clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Cache controller offers an evicted line |
| ld_dirty | input | 1 | Offered line is modified and must be written back |
| ld_tag | input | 28 | Physical line address, bits 31:4 |
| ld_line | input | 128 | Line data, longword n at bits 32n+31:32n |
| busy | output | 1 | Buffer holds a line that is not fully written |
| ld_err | output | 1 | One-cycle pulse: a load was offered while busy |
| fill_req | input | 1 | Fill engine requests or holds the external bus |
| fill_gnt | output | 1 | Fill engine may use the bus this cycle |
| mem_wr_req | output | 1 | Longword write request |
| mem_wr_addr | output | 32 | Byte address of the longword |
| mem_wr_data | output | 32 | Longword data |
| mem_wr_ack | input | 1 | Memory accepts the current longword |

## Verification
Two functions can fall in the same cycle. One is the arrival of a fill request. The other is either a buffer longword awaiting acknowledge, or the gap between two longwords. The bench provokes both cases. It raises `fill_req` while a longword is held by a slow memory, and it judges that `fill_gnt` stays low until the acknowledge and then rises. It also raises `fill_req` at the very negedge on which the memory acknowledges a longword. There it judges that no request appears until the fill drops, and that the scoreboard then receives the remaining longwords in order. A load offered while a line is held is the third collision; it must raise `ld_err` and leave the drained data equal to the first line.

// File: rtl/evb_pkg.sv
package evb_pkg;
  // sequencer states: nothing held, line held but idle, longword in flight
  typedef enum logic [1:0] {
    EVB_EMPTY = 2'd0,
    EVB_HELD  = 2'd1,
    EVB_SEND  = 2'd2
  } evb_state_e;
endpackage

// File: rtl/evb_arb.sv
module evb_arb (
  input  logic fill_req,
  input  logic wr_req,
  output logic fill_gnt,
  output logic may_start
);
  // the fill engine wins the bus unless a longword is already in flight
  always_comb begin
    fill_gnt  = fill_req && !wr_req;
    may_start = !fill_req;
  end
endmodule

// File: rtl/evb_store.sv
module evb_store #(
  parameter int TAG_W  = 28,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    capture,
  input  logic [TAG_W-1:0]        tag_in,
  input  logic [WORDS*WORD_W-1:0] line_in,
  input  logic [SEL_W-1:0]        sel,
  output logic [TAG_W-1:0]        tag_q,
  output logic [WORD_W-1:0]       word_q
);
  logic [WORD_W-1:0] words_q [WORDS];

  // datapath registers: enable only, no reset needed
  always_ff @(posedge clk) begin
    if (capture) tag_q <= tag_in;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (capture) words_q[w] <= line_in[w*WORD_W +: WORD_W];
    end
  end

  always_comb word_q = words_q[sel];
endmodule

// File: rtl/evb_seq.sv
module evb_seq #(
  parameter int WORDS = 4,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_dirty,
  input  logic             may_start,
  input  logic             wr_ack,
  output logic             busy,
  output logic             wr_req,
  output logic             capture,
  output logic             ld_err,
  output logic [SEL_W-1:0] idx
);
  import evb_pkg::*;

  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(WORDS - 1);

  evb_state_e       st_q, st_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    capture = 1'b0;
    err_d   = ld_valid && (st_q != EVB_EMPTY);
    case (st_q)
      EVB_EMPTY: begin
        if (ld_valid && ld_dirty) begin
          st_d    = EVB_HELD;
          idx_d   = '0;
          capture = 1'b1;
        end
      end
      EVB_HELD: begin
        if (may_start) st_d = EVB_SEND;
      end
      EVB_SEND: begin
        if (wr_ack) begin
          if (idx_q == LAST_IDX) begin
            st_d = EVB_EMPTY;
          end else begin
            st_d  = EVB_HELD;
            idx_d = idx_q + SEL_W'(1);
          end
        end
      end
      default: st_d = EVB_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= EVB_EMPTY;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    busy   = (st_q != EVB_EMPTY);
    wr_req = (st_q == EVB_SEND);
    ld_err = err_q;
    idx    = idx_q;
  end
endmodule

// File: rtl/evict_line_buf.sv
module evict_line_buf #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int SEL_W    = $clog2(WORDS),
  localparam int BYTE_OFF = $clog2(WORD_W / 8),
  localparam int TAG_W    = ADDR_W - SEL_W - BYTE_OFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_valid,
  input  logic                    ld_dirty,
  input  logic [TAG_W-1:0]        ld_tag,
  input  logic [WORDS*WORD_W-1:0] ld_line,
  output logic                    busy,
  output logic                    ld_err,
  input  logic                    fill_req,
  output logic                    fill_gnt,
  output logic                    mem_wr_req,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [WORD_W-1:0]       mem_wr_data,
  input  logic                    mem_wr_ack
);
  logic             may_start;
  logic             capture;
  logic [SEL_W-1:0] idx;
  logic [TAG_W-1:0] tag_q;

  evb_arb u_arb (
    .fill_req  (fill_req),
    .wr_req    (mem_wr_req),
    .fill_gnt  (fill_gnt),
    .may_start (may_start)
  );

  evb_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_dirty  (ld_dirty),
    .may_start (may_start),
    .wr_ack    (mem_wr_ack),
    .busy      (busy),
    .wr_req    (mem_wr_req),
    .capture   (capture),
    .ld_err    (ld_err),
    .idx       (idx)
  );

  evb_store #(.TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk     (clk),
    .capture (capture),
    .tag_in  (ld_tag),
    .line_in (ld_line),
    .sel     (idx),
    .tag_q   (tag_q),
    .word_q  (mem_wr_data)
  );

  always_comb mem_wr_addr = {tag_q, idx, {BYTE_OFF{1'b0}}};
endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int SEL_W    = $clog2(WORDS),
  localparam int BYTE_OFF = $clog2(WORD_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_dirty,
  input logic              busy,
  input logic              ld_err,
  input logic              fill_req,
  input logic              fill_gnt,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [WORD_W-1:0] mem_wr_data,
  input logic              mem_wr_ack
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(WORDS - 1);

  p_load_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_valid && ld_dirty) |=> busy);

  p_clean_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_valid && !ld_dirty) |=> (!busy && !mem_wr_req));

  p_start_yields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_req) |-> !$past(fill_req));

  p_bus_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_gnt && mem_wr_req));

  p_req_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_ack_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> !mem_wr_req);

  p_word_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> (busy && mem_wr_addr[BYTE_OFF-1:0] == '0));

  p_last_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack && mem_wr_addr[BYTE_OFF +: SEL_W] == LAST_IDX)
      |=> !busy);

  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_valid) |=> ld_err);

  p_err_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !ld_valid) |=> !ld_err);
endmodule

bind evict_line_buf evb_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_valid    (ld_valid),
  .ld_dirty    (ld_dirty),
  .busy        (busy),
  .ld_err      (ld_err),
  .fill_req    (fill_req),
  .fill_gnt    (fill_gnt),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_ack  (mem_wr_ack)
);

// File: tb/evict_line_buf_tb_top.sv
`timescale 1ns/1ps
module evict_line_buf_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld_valid, ld_dirty;
  logic [27:0]  ld_tag;
  logic [127:0] ld_line;
  logic         busy, ld_err;
  logic         fill_req, fill_gnt;
  logic         mem_wr_req;
  logic [31:0]  mem_wr_addr, mem_wr_data;
  logic         mem_wr_ack;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int words_seen = 0;
  logic [63:0] exp_q [$];

  always #2.5 clk = ~clk;

  evict_line_buf dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_dirty(ld_dirty),
    .ld_tag(ld_tag), .ld_line(ld_line), .busy(busy), .ld_err(ld_err),
    .fill_req(fill_req), .fill_gnt(fill_gnt), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input int seed, input int n);
    return 32'hA5000000 ^ (seed * 32'h01010101) ^ (n << 4) ^ n;
  endfunction

  // driver: offer one line, push expected longwords when it should be written
  task automatic load_line(input logic [27:0] tag, input int seed,
                           input bit dirty, input bit expect_wr);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_dirty = dirty;
    ld_tag   = tag;
    for (int n = 0; n < 4; n++) ld_line[n*32 +: 32] = mk_word(seed, n);
    if (expect_wr)
      for (int n = 0; n < 4; n++)
        exp_q.push_back({tag, 2'(n), 2'b00, mk_word(seed, n)});
    @(negedge clk);
    ld_valid = 1'b0;
    ld_dirty = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int guard = 0;
    while ((busy || exp_q.size() != 0) && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    check(!busy && exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
  endtask

  // monitor / memory model: sample and respond on the falling edge
  int  wait_cnt = 0;
  bit  last_pend = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_ack) begin
        mem_wr_ack <= 1'b0;
        if (last_pend) begin
          check(!busy, "R8 busy clears after last ack", 64'(busy), 64'd0);
          last_pend = 1'b0;
        end
      end else if (mem_wr_req) begin
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3/R9 unexpected write", {mem_wr_addr, mem_wr_data}, 64'd0);
          end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check({mem_wr_addr, mem_wr_data} == e, "R5 longword order/address/data",
                  {mem_wr_addr, mem_wr_data}, e);
            if (mem_wr_addr[3:2] == 2'd3) begin
              check(busy, "R8 busy held through last longword", 64'(busy), 64'd1);
              last_pend = 1'b1;
            end
          end
          mem_wr_ack <= 1'b1;
          words_seen++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; ld_valid = 1'b0; ld_dirty = 1'b0; ld_tag = '0; ld_line = '0;
    fill_req = 1'b0; mem_wr_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1 busy after reset", 64'(busy), 64'd0);
    check(!ld_err, "R1 ld_err after reset", 64'(ld_err), 64'd0);
    check(!mem_wr_req, "R1 mem_wr_req after reset", 64'(mem_wr_req), 64'd0);
    check(!fill_gnt, "R1 fill_gnt after reset", 64'(fill_gnt), 64'd0);

    // R2/R5: plain dirty load, fast memory
    load_line(28'h1234567, 1, 1'b1, 1'b1);
    check(busy, "R2 busy after dirty load", 64'(busy), 64'd1);
    wait_drain("R5 line drained");

    // R3: clean line ignored
    load_line(28'h0BADBAD, 2, 1'b0, 1'b0);
    check(!busy, "R3 clean load ignored", 64'(busy), 64'd0);
    repeat (10) @(negedge clk);
    check(!mem_wr_req && !busy, "R3 no write after clean load", 64'(mem_wr_req), 64'd0);

    // R4: pending fill blocks the start of the burst
    fill_req = 1'b1;
    load_line(28'h2222222, 3, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!mem_wr_req && fill_gnt, "R4 fill keeps the bus",
            {62'd0, mem_wr_req, fill_gnt}, 64'd1);
    end
    fill_req = 1'b0;
    wait_drain("R4 drain after fill");

    // R7: fill arrives between longwords
    lat = 1;
    base = words_seen;
    load_line(28'h3333333, 4, 1'b1, 1'b1);
    wait (words_seen == base + 1);
    fill_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!mem_wr_req, "R7 paused during fill", 64'(mem_wr_req), 64'd0);
    end
    check(words_seen == base + 1, "R7 no word during pause", 64'(words_seen - base), 64'd1);
    fill_req = 1'b0;
    wait_drain("R7 resumed in order");

    // R6/R4: fill arrives while a longword is in flight on slow memory
    lat = 4;
    load_line(28'h4444444, 5, 1'b1, 1'b1);
    while (!mem_wr_req) @(negedge clk);
    fill_req = 1'b1;
    @(negedge clk);
    check(mem_wr_req && !fill_gnt, "R6 word held, fill waits",
          {62'd0, mem_wr_req, fill_gnt}, 64'd2);
    while (mem_wr_req) @(negedge clk);
    check(fill_gnt, "R4 fill granted after ack", 64'(fill_gnt), 64'd1);
    repeat (3) @(negedge clk);
    fill_req = 1'b0;
    wait_drain("R6 slow drain");

    // R9: loads while busy (dirty and clean) are flagged, line kept
    lat = 0;
    fill_req = 1'b1;
    load_line(28'h5555555, 6, 1'b1, 1'b1);
    load_line(28'h6666666, 7, 1'b1, 1'b0);
    check(ld_err, "R9 error on dirty load while busy", 64'(ld_err), 64'd1);
    @(negedge clk);
    check(!ld_err, "R9 error is one cycle", 64'(ld_err), 64'd0);
    load_line(28'h7777777, 8, 1'b0, 1'b0);
    check(ld_err, "R9 error on clean load while busy", 64'(ld_err), 64'd1);
    fill_req = 1'b0;
    wait_drain("R9 first line kept");

    // R8: new load accepted right after busy falls
    load_line(28'h0000001, 9, 1'b1, 1'b1);
    check(busy, "R8 load accepted after drain", 64'(busy), 64'd1);
    wait_drain("R8 second line drained");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule